// File: doc/BRIEF.md
# Four-Mode Mini ALU with Two-Glyph Operation Code

This block is the execute stage of a small teaching processor. Two 4-bit operands and a two-level opcode go in. The opcode is a 2-bit mode and a 2-bit function inside that mode. One clock later the block presents an 8-bit result and a two-character operation code. The code is given as two 5-bit glyph indices that a seven-segment decoder elsewhere turns into letters.

The modes are unsigned arithmetic, bitwise logic, comparison and signed arithmetic. Some operations treat the operands as two separate nibbles. The shifts and the inversion instead act on the byte formed by placing operand A above operand B. Every result and both glyphs are taken into one output register on the rising clock edge. The outputs are therefore stable for a whole cycle while the operand switches move.

Top module: `mini_alu`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, result is 8'h00 and both glyph outputs hold the blank index 31.
- R2: The outputs follow the inputs sampled at the previous rising clock edge. A change of inputs between edges leaves the outputs unchanged until the next edge.
- R3: In mode 2'b00, function 2'b00 returns the 5-bit sum A+B zero-extended to 8 bits. Function 2'b01 returns (A-B) mod 16 zero-extended to 8 bits.
- R4: In mode 2'b00, function 2'b10 returns {A,B} shifted left by one, with the carry out of bit 7 dropped. Function 2'b11 returns {A,B} shifted right by one, with a zero entering bit 7.
- R5: In mode 2'b01, functions 2'b00, 2'b01 and 2'b10 return the 4-bit AND, OR and XOR of A and B, zero-extended. Function 2'b11 returns the 8-bit inverse of {A,B}.
- R6: In mode 2'b10, functions 2'b00, 2'b01 and 2'b10 return 8'h01 when A==B, A>B and A<B respectively, and 8'h00 otherwise. The operands are compared unsigned.
- R7: In mode 2'b10, function 2'b11 returns the larger of A and B, zero-extended. When they are equal it returns B.
- R8: In mode 2'b11, function 2'b00 returns the low 4 bits of A+B and function 2'b01 returns the low 4 bits of A-B. In both cases bit 3 is copied into bits 7:4, so 8+4 and 4-8 both give 8'hFC.
- R9: In mode 2'b11, functions 2'b10 and 2'b11 return 8'h00 with both glyphs blank.
- R10: The glyph encoding is: indices 0 to 15 are the hex digits, with 10=A and 12=C, 13=d and 14=E. Further, 16=H, 17=L, 18=n, 19=P and 31=blank. glyph_hi/glyph_lo show AA, A5, AP, Ad for the arithmetic mode and LA, L0, LH, Ln for the logic mode. They show CE, C6, CL, CH for the comparison mode and SA, S5 for signed add and subtract, where S uses index 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode | input | 2 | Operation group |
| op_fn | input | 2 | Operation within the group |
| opnd_a | input | 4 | Operand A, upper nibble of the byte operand |
| opnd_b | input | 4 | Operand B, lower nibble of the byte operand |
| result | output | 8 | Registered operation result |
| glyph_hi | output | 5 | Left character of the operation code |
| glyph_lo | output | 5 | Right character of the operation code |

## Verification
The only state is the output register, so any fault shows within one cycle of the opcode that exercises it. Examples are a wrong mux leg, a wrong operand width, or a sign bit taken from the wrong place. A fault in a comparison shows as a nonzero bit above bit 0. A fault in the maximum shows as a value that matches neither operand. A fault in a signed operation breaks the copy of bit 3 into the upper nibble. The stimulus walks every mode and function with equal operands, operands at opposite extremes, and the carry and borrow edges. This way a one-bit slip in any leg changes a compared value on the next edge.

// File: rtl/mini_alu_pkg.sv
package mini_alu_pkg;

    localparam int GLYPH_W = 5;
    typedef logic [GLYPH_W-1:0] glyph_t;

    // Glyph indices: hex digits 0..15, then extra letters, 31 blank
    localparam glyph_t GL_0     = 5'd0;
    localparam glyph_t GL_5     = 5'd5;
    localparam glyph_t GL_6     = 5'd6;
    localparam glyph_t GL_A     = 5'd10;
    localparam glyph_t GL_C     = 5'd12;
    localparam glyph_t GL_D     = 5'd13;
    localparam glyph_t GL_E     = 5'd14;
    localparam glyph_t GL_H     = 5'd16;
    localparam glyph_t GL_L     = 5'd17;
    localparam glyph_t GL_N     = 5'd18;
    localparam glyph_t GL_P     = 5'd19;
    localparam glyph_t GL_BLANK = 5'd31;

    typedef enum logic [1:0] {
        MODE_ARITH  = 2'b00,
        MODE_LOGIC  = 2'b01,
        MODE_CMP    = 2'b10,
        MODE_SIGNED = 2'b11
    } mode_e;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int NIB_W = 4
) (
    input  logic [1:0]         fn,
    input  logic [NIB_W-1:0]   a,
    input  logic [NIB_W-1:0]   b,
    output logic [2*NIB_W-1:0] uns_res,
    output logic [2*NIB_W-1:0] sgn_res
);
    localparam int WIDE_W = 2 * NIB_W;

    logic [WIDE_W-1:0] wide;
    logic [NIB_W:0]    sum;
    logic [NIB_W-1:0]  diff;
    logic [NIB_W-1:0]  pick;

    always_comb begin
        wide = {a, b};
        sum  = {1'b0, a} + {1'b0, b};
        diff = a - b;

        unique case (fn)
            2'b00:   uns_res = {{(WIDE_W-NIB_W-1){1'b0}}, sum};
            2'b01:   uns_res = {{(WIDE_W-NIB_W){1'b0}}, diff};
            2'b10:   uns_res = wide << 1;
            default: uns_res = wide >> 1;
        endcase

        // Signed forms: wrap to the nibble, then copy its sign upward
        pick = fn[0] ? diff : sum[NIB_W-1:0];
        if (fn[1])
            sgn_res = '0;
        else
            sgn_res = {{(WIDE_W-NIB_W){pick[NIB_W-1]}}, pick};
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int NIB_W = 4
) (
    input  logic [1:0]         fn,
    input  logic [NIB_W-1:0]   a,
    input  logic [NIB_W-1:0]   b,
    output logic [2*NIB_W-1:0] res
);
    localparam int PAD_W = NIB_W;

    always_comb begin
        unique case (fn)
            2'b00:   res = {{PAD_W{1'b0}}, a & b};
            2'b01:   res = {{PAD_W{1'b0}}, a | b};
            2'b10:   res = {{PAD_W{1'b0}}, a ^ b};
            default: res = ~{a, b};
        endcase
    end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int NIB_W = 4
) (
    input  logic [1:0]         fn,
    input  logic [NIB_W-1:0]   a,
    input  logic [NIB_W-1:0]   b,
    output logic [2*NIB_W-1:0] res
);
    localparam int WIDE_W = 2 * NIB_W;

    logic a_gt, a_eq, a_lt;

    always_comb begin
        a_gt = (a > b);
        a_eq = (a == b);
        a_lt = (a < b);
        res  = '0;
        unique case (fn)
            2'b00:   res[0] = a_eq;
            2'b01:   res[0] = a_gt;
            2'b10:   res[0] = a_lt;
            // Max is steered by the greater-than flag alone
            default: res = {{(WIDE_W-NIB_W){1'b0}}, (a_gt ? a : b)};
        endcase
    end
endmodule

// File: rtl/alu_glyph.sv
module alu_glyph
    import mini_alu_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [1:0] fn,
    output glyph_t     hi,
    output glyph_t     lo
);
    always_comb begin
        hi = GL_BLANK;
        lo = GL_BLANK;
        unique case (mode_e'(mode))
            MODE_ARITH: begin
                hi = GL_A;
                unique case (fn)
                    2'b00:   lo = GL_A;
                    2'b01:   lo = GL_5;
                    2'b10:   lo = GL_P;
                    default: lo = GL_D;
                endcase
            end
            MODE_LOGIC: begin
                hi = GL_L;
                unique case (fn)
                    2'b00:   lo = GL_A;
                    2'b01:   lo = GL_0;
                    2'b10:   lo = GL_H;
                    default: lo = GL_N;
                endcase
            end
            MODE_CMP: begin
                hi = GL_C;
                unique case (fn)
                    2'b00:   lo = GL_E;
                    2'b01:   lo = GL_6;
                    2'b10:   lo = GL_L;
                    default: lo = GL_H;
                endcase
            end
            default: begin
                if (!fn[1]) begin
                    hi = GL_5;
                    lo = fn[0] ? GL_5 : GL_A;
                end
            end
        endcase
    end
endmodule

// File: rtl/mini_alu.sv
module mini_alu
    import mini_alu_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         op_mode,
    input  logic [1:0]         op_fn,
    input  logic [NIB_W-1:0]   opnd_a,
    input  logic [NIB_W-1:0]   opnd_b,
    output logic [2*NIB_W-1:0] result,
    output logic [GLYPH_W-1:0] glyph_hi,
    output logic [GLYPH_W-1:0] glyph_lo
);
    localparam int WIDE_W = 2 * NIB_W;

    typedef struct packed {
        logic [WIDE_W-1:0] res;
        glyph_t            hi;
        glyph_t            lo;
    } out_t;

    logic [WIDE_W-1:0] arith_uns, arith_sgn, logic_res, cmp_res;
    glyph_t            g_hi, g_lo;
    out_t              out_d, out_q;

    alu_arith #(.NIB_W(NIB_W)) u_arith (
        .fn(op_fn), .a(opnd_a), .b(opnd_b),
        .uns_res(arith_uns), .sgn_res(arith_sgn)
    );

    alu_logic #(.NIB_W(NIB_W)) u_logic (
        .fn(op_fn), .a(opnd_a), .b(opnd_b), .res(logic_res)
    );

    alu_compare #(.NIB_W(NIB_W)) u_cmp (
        .fn(op_fn), .a(opnd_a), .b(opnd_b), .res(cmp_res)
    );

    alu_glyph u_glyph (
        .mode(op_mode), .fn(op_fn), .hi(g_hi), .lo(g_lo)
    );

    always_comb begin
        out_d    = out_q;
        out_d.hi = g_hi;
        out_d.lo = g_lo;
        unique case (mode_e'(op_mode))
            MODE_ARITH: out_d.res = arith_uns;
            MODE_LOGIC: out_d.res = logic_res;
            MODE_CMP:   out_d.res = cmp_res;
            default:    out_d.res = arith_sgn;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.res <= '0;
            out_q.hi  <= GL_BLANK;
            out_q.lo  <= GL_BLANK;
        end else begin
            out_q <= out_d;
        end
    end

    assign result   = out_q.res;
    assign glyph_hi = out_q.hi;
    assign glyph_lo = out_q.lo;
endmodule

// File: rtl/mini_alu_chk.sv
module mini_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] op_mode,
    input logic [1:0] op_fn,
    input logic [3:0] opnd_a,
    input logic [3:0] opnd_b,
    input logic [7:0] result,
    input logic [4:0] glyph_hi,
    input logic [4:0] glyph_lo
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (result == 8'h00 && glyph_hi == 5'd31 && glyph_lo == 5'd31));

    assert_logic_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b01 && op_fn != 2'b11) |=> (result[7:4] == 4'h0));

    assert_flag_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b10 && op_fn != 2'b11) |=> (result[7:1] == 7'h00 && glyph_hi == 5'd12));

    assert_max_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b10 && op_fn == 2'b11) |=>
            (result[7:4] == 4'h0 && result[3:0] >= $past(opnd_a) && result[3:0] >= $past(opnd_b)
             && (result[3:0] == $past(opnd_a) || result[3:0] == $past(opnd_b))));

    assert_sign_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b11 && !op_fn[1]) |=> (result[7:4] == {4{result[3]}} && glyph_hi == 5'd5));

    assert_unused_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b11 && op_fn[1]) |=> (result == 8'h00 && glyph_hi == 5'd31 && glyph_lo == 5'd31));
endmodule

bind mini_alu mini_alu_chk u_chk (.*);

// File: tb/sim_mini_alu.sv
`timescale 1ns/1ps
module sim_mini_alu;

    typedef struct packed {
        logic [7:0] res;
        logic [4:0] hi;
        logic [4:0] lo;
        logic [3:0] tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_mode = '0;
    logic [1:0] op_fn = '0;
    logic [3:0] opnd_a = '0;
    logic [3:0] opnd_b = '0;
    logic [7:0] result;
    logic [4:0] glyph_hi, glyph_lo;

    int   n_run = 0;
    int   n_fail = 0;
    exp_t sb[$];
    bit   done = 1'b0;

    always #4 clk = ~clk;

    mini_alu u0 (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .op_fn(op_fn),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .glyph_hi(glyph_hi), .glyph_lo(glyph_lo)
    );

    // Reference model written from the requirement list
    function automatic exp_t model(input logic [1:0] m, input logic [1:0] f,
                                   input logic [3:0] a, input logic [3:0] b);
        exp_t e;
        logic [4:0] s5;
        logic [3:0] w;
        e.res = 8'h00; e.hi = 5'd31; e.lo = 5'd31; e.tag = 4'd0;
        case (m)
            2'b00: begin
                e.hi = 5'd10;
                case (f)
                    2'b00: begin s5 = a + b; e.res = {3'b000, s5}; e.lo = 5'd10; e.tag = 3; end // R3
                    2'b01: begin w = a - b; e.res = {4'h0, w}; e.lo = 5'd5; e.tag = 3; end     // R3
                    2'b10: begin e.res = {a, b} << 1; e.lo = 5'd19; e.tag = 4; end             // R4
                    default: begin e.res = {a, b} >> 1; e.lo = 5'd13; e.tag = 4; end          // R4
                endcase
            end
            2'b01: begin
                e.hi = 5'd17; e.tag = 5; // R5
                case (f)
                    2'b00: begin e.res = {4'h0, a & b}; e.lo = 5'd10; end
                    2'b01: begin e.res = {4'h0, a | b}; e.lo = 5'd0; end
                    2'b10: begin e.res = {4'h0, a ^ b}; e.lo = 5'd16; end
                    default: begin e.res = ~{a, b}; e.lo = 5'd18; end
                endcase
            end
            2'b10: begin
                e.hi = 5'd12; e.tag = 6; // R6
                case (f)
                    2'b00: begin e.res = (a == b) ? 8'h01 : 8'h00; e.lo = 5'd14; end
                    2'b01: begin e.res = (a > b) ? 8'h01 : 8'h00; e.lo = 5'd6; end
                    2'b10: begin e.res = (a < b) ? 8'h01 : 8'h00; e.lo = 5'd17; end
                    default: begin e.res = {4'h0, (a > b) ? a : b}; e.lo = 5'd16; e.tag = 7; end // R7
                endcase
            end
            default: begin
                if (f[1]) begin
                    e.tag = 9; // R9
                end else begin
                    w = f[0] ? (a - b) : (a + b);
                    e.res = {{4{w[3]}}, w};
                    e.hi = 5'd5; e.lo = f[0] ? 5'd5 : 5'd10; e.tag = 8; // R8
                end
            end
        endcase
        return e;
    endfunction

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got res=%h hi=%0d lo=%0d, expected res=%h hi=%0d lo=%0d",
                     req, act[17:10], act[9:5], act[4:0], exp[17:10], exp[9:5], exp[4:0]);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [1:0] f,
                         input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        op_mode = m; op_fn = f; opnd_a = a; opnd_b = b;
        sb.push_back(model(m, f, a, b));
    endtask

    // Monitor: every item pushed before an edge is visible 2 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check($sformatf("R%0d", e.tag), {result, glyph_hi, glyph_lo}, {e.res, e.hi, e.lo});
                // The glyph pair is part of every item: R10
                check("R10", {8'h00, glyph_hi, glyph_lo}, {8'h00, e.hi, e.lo});
            end
        end
    end

    initial begin
        #(8 * 200000);
        $display("FAIL watchdog: got no finish, expected finish");
        n_run++; n_fail++;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset holds zero and blanks even with live inputs
        op_mode = 2'b01; op_fn = 2'b11; opnd_a = 4'h3; opnd_b = 4'h5;
        repeat (3) @(posedge clk);
        #2 check("R1", {result, glyph_hi, glyph_lo}, {8'h00, 5'd31, 5'd31});
        @(negedge clk); rst_n = 1'b1;
        #1 check("R1", {result, glyph_hi, glyph_lo}, {8'h00, 5'd31, 5'd31});
        @(posedge clk); #1;

        // R3 carry and borrow edges
        drive(2'b00, 2'b00, 4'hF, 4'hF);
        drive(2'b00, 2'b00, 4'h7, 4'h8);
        drive(2'b00, 2'b01, 4'h3, 4'h5);
        drive(2'b00, 2'b01, 4'h9, 4'h2);
        // R4 shifts on the byte
        drive(2'b00, 2'b10, 4'hC, 4'h3);
        drive(2'b00, 2'b11, 4'hC, 4'h3);
        drive(2'b00, 2'b11, 4'h0, 4'h1);
        // R5
        drive(2'b01, 2'b00, 4'hC, 4'hA);
        drive(2'b01, 2'b01, 4'hC, 4'hA);
        drive(2'b01, 2'b10, 4'hC, 4'hA);
        drive(2'b01, 2'b11, 4'h3, 4'hA);
        // R6 with equal and ordered operands
        drive(2'b10, 2'b00, 4'h6, 4'h6);
        drive(2'b10, 2'b00, 4'h6, 4'h7);
        drive(2'b10, 2'b01, 4'h9, 4'h8);
        drive(2'b10, 2'b01, 4'h8, 4'h8);
        drive(2'b10, 2'b10, 4'h0, 4'hF);
        drive(2'b10, 2'b10, 4'hF, 4'hF);
        // R7
        drive(2'b10, 2'b11, 4'hA, 4'h4);
        drive(2'b10, 2'b11, 4'h2, 4'hE);
        drive(2'b10, 2'b11, 4'h5, 4'h5);
        // R8 examples and a non-negative case
        drive(2'b11, 2'b00, 4'h8, 4'h4);
        drive(2'b11, 2'b01, 4'h4, 4'h8);
        drive(2'b11, 2'b00, 4'h2, 4'h3);
        drive(2'b11, 2'b01, 4'h7, 4'hF);
        // R9
        drive(2'b11, 2'b10, 4'hF, 4'hF);
        drive(2'b11, 2'b11, 4'h8, 4'h1);
        // Full sweep of every opcode for R10
        for (int m = 0; m < 4; m++)
            for (int f = 0; f < 4; f++)
                drive(2'(m), 2'(f), 4'(m * 5 + f), 4'(15 - f * 3));

        // R2: a mid-cycle input change does not reach the outputs early
        drive(2'b00, 2'b00, 4'h1, 4'h1);
        @(posedge clk); #3;
        op_mode = 2'b01; op_fn = 2'b11; opnd_a = 4'h0; opnd_b = 4'h0;
        #1 check("R2", {result, glyph_hi, glyph_lo}, {8'h02, 5'd10, 5'd10});
        @(posedge clk); #2;
        check("R2", {result, glyph_hi, glyph_lo}, {8'hFF, 5'd17, 5'd18});

        repeat (2) @(posedge clk);
        #3;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule